// File: doc/BRIEF.md
# Prioritized interrupt vector tracker

This block keeps track of which of a processor's interrupt vectors are waiting to be taken and which are currently being serviced. Each vector has a pending bit, an in-service bit and a trigger-mode bit. All three arrays are stored as words, and the vector number picks both the word and the bit inside it. When several vectors compete, the one with the smallest vector number is the most urgent.

A source posts a vector with its trigger mode on the request port. The core raises an acknowledge strobe to take the most urgent pending vector. One cycle later the block answers with that vector number, or with a "nothing" answer when the controller is disabled by software or nothing is pending. When the handler finishes, an end-of-interrupt strobe retires the most urgent in-service vector. The interrupt line to the core is raised only while the best pending vector beats everything already in service. The current service level is shown on a priority output, and any word of the three arrays can be read out.

Top module: `vt_tracker`

## Requirements
- R1: Reading uses a word select. Bit b of word w stands for vector w*32+b. The pending, in-service and trigger-mode words for the selected word appear on the read outputs one cycle after the select is sampled, and they show the state as it was before that edge.
- R2: A request sets the pending bit of its vector. It also sets the vector's trigger-mode bit when the level input is 1, and clears it when the level input is 0.
- R3: Priority searches always favour the lowest vector number: word 0 is searched first, and within a word the lowest set bit wins.
- R4: The interrupt line is 1 exactly when some vector is pending and either nothing is in service or the best pending number is smaller than the best in-service number. It reflects the state held after each clock edge.
- R5: An acknowledge with software enable at 1 and some vector pending moves the best pending vector from pending to in-service. In the next cycle it returns ack_valid=1, ack_none=0 and ack_vec equal to that vector.
- R6: An acknowledge with software enable at 0, or with nothing pending, returns ack_valid=1, ack_none=1 and ack_vec=0 in the next cycle, and changes no state. ack_valid is 0 in any cycle that does not follow an acknowledge.
- R7: An end-of-interrupt clears the in-service bit of the lowest-numbered in-service vector. It has no effect when nothing is in service.
- R8: ppr_vec shows the lowest in-service vector number and ppr_idle is 0 while any vector is in service. When nothing is in service, ppr_idle is 1 and ppr_vec is 0.
- R9: When an acknowledge and a request for the vector that the acknowledge takes fall in the same cycle, the pending bit ends cleared. The trigger-mode bit still follows the request.
- R10: When an acknowledge and an end-of-interrupt fall in the same cycle, both act on the state from before that edge. If they touch the same in-service bit, the acknowledge's set wins.
- R11: Reset clears all three arrays and drives the interrupt line and ack_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Post a request this cycle |
| req_vec | input | 8 | Requested vector number |
| req_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack_req | input | 1 | Acknowledge strobe from the core |
| eoi | input | 1 | End-of-interrupt strobe |
| sw_enable | input | 1 | Software enable for acknowledge |
| rd_word | input | 3 | Word select for read access |
| irq | output | 1 | Interrupt request to the core |
| ack_valid | output | 1 | Acknowledge answer present |
| ack_none | output | 1 | Answer carries no vector |
| ack_vec | output | 8 | Vector taken by the acknowledge |
| ppr_vec | output | 8 | Lowest in-service vector |
| ppr_idle | output | 1 | Nothing in service |
| rd_pend | output | 32 | Pending word read out |
| rd_serv | output | 32 | In-service word read out |
| rd_trig | output | 32 | Trigger-mode word read out |

## Verification
The acknowledge can coincide with a request for the same vector, or with an end-of-interrupt. Each case settles which update wins on a single bit. Directed steps create a single pending vector and then raise acknowledge together with a new level request for that vector. Other directed steps raise acknowledge together with end-of-interrupt while another vector is in service. The outcome is judged through the read port and the priority output. Random traffic then mixes all strobes in the same cycles, and a bench model that applies the precedence order in the requirements judges every cycle.

// File: rtl/vt_pkg.sv
package vt_pkg;
  parameter int DEF_NUM_VEC = 256;
  parameter int DEF_WORD_W  = 32;

  // Lowest set bit of a word; returns its position, found flag separate.
  function automatic int unsigned first_set_pos(input logic [DEF_WORD_W-1:0] w);
    int unsigned pos;
    pos = 0;
    for (int i = DEF_WORD_W - 1; i >= 0; i--) begin
      if (w[i]) pos = i;
    end
    return pos;
  endfunction
endpackage

// File: rtl/vt_lowest_set.sv
module vt_lowest_set #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int SEL_W = $clog2(WORDS),
  localparam int IDX_W = BIT_W + SEL_W
) (
  input  logic [WORDS*WORD_W-1:0] bits,
  output logic                    found,
  output logic [IDX_W-1:0]        idx
);
  logic [WORDS-1:0] word_any;
  logic [BIT_W-1:0] word_pos [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] slice;
    assign slice       = bits[w*WORD_W +: WORD_W];
    assign word_any[w] = |slice;
    always_comb begin
      word_pos[w] = '0;
      for (int b = WORD_W - 1; b >= 0; b--) begin
        if (slice[b]) word_pos[w] = BIT_W'(b);
      end
    end
  end

  always_comb begin
    found = |word_any;
    idx   = '0;
    for (int w = WORDS - 1; w >= 0; w--) begin
      if (word_any[w]) idx = {SEL_W'(w), word_pos[w]};
    end
  end
endmodule

// File: rtl/vt_word_next.sv
module vt_word_next #(
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] pend_cur,
  input  logic [WORD_W-1:0] serv_cur,
  input  logic [WORD_W-1:0] trig_cur,
  input  logic              req_hit,
  input  logic [BIT_W-1:0]  req_bit,
  input  logic              req_lvl,
  input  logic              ack_hit,
  input  logic [BIT_W-1:0]  ack_bit,
  input  logic              eoi_hit,
  input  logic [BIT_W-1:0]  eoi_bit,
  output logic [WORD_W-1:0] pend_nxt,
  output logic [WORD_W-1:0] serv_nxt,
  output logic [WORD_W-1:0] trig_nxt
);
  logic [WORD_W-1:0] req_oh, ack_oh, eoi_oh;

  assign req_oh = WORD_W'(1) << req_bit;
  assign ack_oh = WORD_W'(1) << ack_bit;
  assign eoi_oh = WORD_W'(1) << eoi_bit;

  always_comb begin
    pend_nxt = pend_cur;
    serv_nxt = serv_cur;
    trig_nxt = trig_cur;
    // request first, then acknowledge clear overrides it
    if (req_hit) begin
      pend_nxt = pend_nxt | req_oh;
      trig_nxt = req_lvl ? (trig_nxt | req_oh) : (trig_nxt & ~req_oh);
    end
    if (ack_hit) pend_nxt = pend_nxt & ~ack_oh;
    // retire first, then acknowledge set overrides it
    if (eoi_hit) serv_nxt = serv_nxt & ~eoi_oh;
    if (ack_hit) serv_nxt = serv_nxt | ack_oh;
  end
endmodule

// File: rtl/vt_tracker.sv
module vt_tracker #(
  parameter int NUM_VEC = vt_pkg::DEF_NUM_VEC,
  parameter int WORD_W  = vt_pkg::DEF_WORD_W,
  localparam int WORDS  = NUM_VEC / WORD_W,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int SEL_W  = $clog2(WORDS),
  localparam int IDX_W  = BIT_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_vec,
  input  logic              req_level,
  input  logic              ack_req,
  input  logic              eoi,
  input  logic              sw_enable,
  input  logic [SEL_W-1:0]  rd_word,
  output logic              irq,
  output logic              ack_valid,
  output logic              ack_none,
  output logic [IDX_W-1:0]  ack_vec,
  output logic [IDX_W-1:0]  ppr_vec,
  output logic              ppr_idle,
  output logic [WORD_W-1:0] rd_pend,
  output logic [WORD_W-1:0] rd_serv,
  output logic [WORD_W-1:0] rd_trig
);
  logic [WORD_W-1:0] pend_q [WORDS];
  logic [WORD_W-1:0] serv_q [WORDS];
  logic [WORD_W-1:0] trig_q [WORDS];
  logic [WORD_W-1:0] pend_d [WORDS];
  logic [WORD_W-1:0] serv_d [WORDS];
  logic [WORD_W-1:0] trig_d [WORDS];

  logic [NUM_VEC-1:0] pend_flat, serv_flat;
  logic               pend_any, serv_any;
  logic [IDX_W-1:0]   pend_idx, serv_idx;
  logic               ack_fire, eoi_fire;

  for (genvar w = 0; w < WORDS; w++) begin : g_flat
    assign pend_flat[w*WORD_W +: WORD_W] = pend_q[w];
    assign serv_flat[w*WORD_W +: WORD_W] = serv_q[w];
  end

  vt_lowest_set #(.WORDS(WORDS), .WORD_W(WORD_W)) u_pend_pick (
    .bits(pend_flat), .found(pend_any), .idx(pend_idx)
  );
  vt_lowest_set #(.WORDS(WORDS), .WORD_W(WORD_W)) u_serv_pick (
    .bits(serv_flat), .found(serv_any), .idx(serv_idx)
  );

  assign ack_fire = ack_req & sw_enable & pend_any;
  assign eoi_fire = eoi & serv_any;

  for (genvar w = 0; w < WORDS; w++) begin : g_upd
    logic req_hit, ack_hit, eoi_hit;
    assign req_hit = req_valid & (req_vec[IDX_W-1:BIT_W] == SEL_W'(w));
    assign ack_hit = ack_fire  & (pend_idx[IDX_W-1:BIT_W] == SEL_W'(w));
    assign eoi_hit = eoi_fire  & (serv_idx[IDX_W-1:BIT_W] == SEL_W'(w));
    vt_word_next #(.WORD_W(WORD_W)) u_next (
      .pend_cur(pend_q[w]), .serv_cur(serv_q[w]), .trig_cur(trig_q[w]),
      .req_hit(req_hit), .req_bit(req_vec[BIT_W-1:0]), .req_lvl(req_level),
      .ack_hit(ack_hit), .ack_bit(pend_idx[BIT_W-1:0]),
      .eoi_hit(eoi_hit), .eoi_bit(serv_idx[BIT_W-1:0]),
      .pend_nxt(pend_d[w]), .serv_nxt(serv_d[w]), .trig_nxt(trig_d[w])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) begin
        pend_q[w] <= '0;
        serv_q[w] <= '0;
        trig_q[w] <= '0;
      end
      ack_valid <= 1'b0;
      ack_none  <= 1'b1;
      ack_vec   <= '0;
      rd_pend   <= '0;
      rd_serv   <= '0;
      rd_trig   <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        pend_q[w] <= pend_d[w];
        serv_q[w] <= serv_d[w];
        trig_q[w] <= trig_d[w];
      end
      ack_valid <= ack_req;
      ack_none  <= ~ack_fire;
      ack_vec   <= ack_fire ? pend_idx : '0;
      rd_pend   <= pend_q[rd_word];
      rd_serv   <= serv_q[rd_word];
      rd_trig   <= trig_q[rd_word];
    end
  end

  assign irq      = pend_any & (~serv_any | (pend_idx < serv_idx));
  assign ppr_idle = ~serv_any;
  assign ppr_vec  = serv_any ? serv_idx : '0;
endmodule

// File: rtl/vt_tracker_chk.sv
module vt_tracker_chk #(
  parameter int NUM_VEC = 256,
  parameter int IDX_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ack_req,
  input logic               eoi,
  input logic               sw_enable,
  input logic               irq,
  input logic               ack_valid,
  input logic               ack_none,
  input logic [IDX_W-1:0]   ack_vec,
  input logic [IDX_W-1:0]   ppr_vec,
  input logic               ppr_idle,
  input logic [NUM_VEC-1:0] pend_flat,
  input logic [NUM_VEC-1:0] serv_flat
);
  // R11
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq && !ack_valid));
  // R4
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend_flat != '0));
  // R6
  disabled_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_req && !sw_enable) |=> (ack_valid && ack_none && ack_vec == '0));
  // R6
  ack_answer_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_req |=> !ack_valid);
  // R5
  ack_taken_in_service_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !ack_none) |-> (serv_flat[ack_vec] && !ppr_idle && ppr_vec <= ack_vec));
  // R7
  eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi && ppr_idle && !ack_req) |=> ppr_idle);
  // R8
  ppr_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ppr_idle |-> (ppr_vec == '0 && serv_flat == '0));
endmodule

bind vt_tracker vt_tracker_chk #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_vt_chk (
  .clk(clk), .rst(rst), .ack_req(ack_req), .eoi(eoi), .sw_enable(sw_enable),
  .irq(irq), .ack_valid(ack_valid), .ack_none(ack_none), .ack_vec(ack_vec),
  .ppr_vec(ppr_vec), .ppr_idle(ppr_idle),
  .pend_flat(pend_flat), .serv_flat(serv_flat)
);

// File: tb/vt_tracker_tb_top.sv
module vt_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 256;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_level, ack_req, eoi, sw_enable;
  logic [7:0]  req_vec;
  logic [2:0]  rd_word;
  logic        irq, ack_valid, ack_none, ppr_idle;
  logic [7:0]  ack_vec, ppr_vec;
  logic [31:0] rd_pend, rd_serv, rd_trig;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [NV-1:0] m_pend, m_serv, m_trig;
  logic          e_ackv, e_none;
  logic [7:0]    e_ackvec;
  logic [31:0]   e_rp, e_rs, e_rt;

  always #(CLK_PERIOD/2) clk = ~clk;

  vt_tracker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec),
    .req_level(req_level), .ack_req(ack_req), .eoi(eoi), .sw_enable(sw_enable),
    .rd_word(rd_word), .irq(irq), .ack_valid(ack_valid), .ack_none(ack_none),
    .ack_vec(ack_vec), .ppr_vec(ppr_vec), .ppr_idle(ppr_idle),
    .rd_pend(rd_pend), .rd_serv(rd_serv), .rd_trig(rd_trig)
  );

  function automatic int lowest(input logic [NV-1:0] v);
    for (int i = 0; i < NV; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    int pb, sb;
    pb = lowest(m_pend);
    sb = lowest(m_serv);
    chk("R4 irq", 32'(irq), 32'(pb >= 0 && (sb < 0 || pb < sb)));
    chk("R8 ppr_idle", 32'(ppr_idle), 32'(sb < 0));
    chk("R8 ppr_vec", 32'(ppr_vec), (sb < 0) ? 32'd0 : 32'(sb));
    chk("R6 ack_valid", 32'(ack_valid), 32'(e_ackv));
    if (e_ackv) begin
      chk(e_none ? "R6 ack_none" : "R5 ack_none", 32'(ack_none), 32'(e_none));
      chk(e_none ? "R6 ack_vec" : "R5 ack_vec", 32'(ack_vec), 32'(e_ackvec));
    end
    chk("R1 rd_pend", rd_pend, e_rp);
    chk("R1 rd_serv", rd_serv, e_rs);
    chk("R1 rd_trig", rd_trig, e_rt);
  endtask

  // Drive one cycle, update the model, wait past the edge, then compare.
  task automatic step(input logic rv, input logic [7:0] rvec, input logic rl,
                      input logic ak, input logic eo, input logic en,
                      input logic [2:0] rw);
    int pb, sb;
    logic fire;
    req_valid = rv; req_vec = rvec; req_level = rl;
    ack_req = ak; eoi = eo; sw_enable = en; rd_word = rw;
    pb = lowest(m_pend);
    sb = lowest(m_serv);
    e_rp = m_pend[rw*32 +: 32];
    e_rs = m_serv[rw*32 +: 32];
    e_rt = m_trig[rw*32 +: 32];
    fire = ak && en && (pb >= 0);
    if (rv) begin
      m_pend[rvec] = 1'b1;
      m_trig[rvec] = rl;
    end
    if (fire) m_pend[pb] = 1'b0;                 // R9 ack clear wins
    if (eo && sb >= 0) m_serv[sb] = 1'b0;        // R7
    if (fire) m_serv[pb] = 1'b1;                 // R10 ack set wins
    e_ackv = ak;
    e_none = !fire;
    e_ackvec = fire ? 8'(pb) : 8'd0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; ack_req = 0; eoi = 0;
    check_outputs();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4711));
    rst = 1; req_valid = 0; req_vec = 0; req_level = 0;
    ack_req = 0; eoi = 0; sw_enable = 1; rd_word = 0;
    m_pend = '0; m_serv = '0; m_trig = '0;
    e_ackv = 0; e_none = 1; e_ackvec = 0; e_rp = 0; e_rs = 0; e_rt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 irq", 32'(irq), 0);
    chk("R11 ack_valid", 32'(ack_valid), 0);
    chk("R11 ppr_idle", 32'(ppr_idle), 1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R11 rd_pend", rd_pend, 0);

    // R2 requests with both trigger modes
    step(1, 8'd70, 1, 0, 0, 1, 0);
    step(1, 8'd40, 0, 0, 0, 1, 0);
    step(1, 8'd33, 1, 0, 0, 1, 2);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R2 pend word1", rd_pend, 32'h0000_0102);
    chk("R2 trig word1", rd_trig, 32'h0000_0002);
    step(0, 0, 0, 0, 0, 1, 2);
    chk("R2 trig word2", rd_trig, 32'h0000_0040);

    // R3 lowest number wins
    step(0, 0, 0, 1, 0, 1, 0);
    chk("R3 ack_vec", 32'(ack_vec), 33);
    chk("R4 blocked irq", 32'(irq), 0);
    step(1, 8'd5, 0, 0, 0, 1, 0);
    chk("R4 raised irq", 32'(irq), 1);

    // R10 ack and eoi together: eoi retires 33, ack takes 5
    step(0, 0, 0, 1, 1, 1, 0);
    chk("R10 ack_vec", 32'(ack_vec), 5);
    chk("R10 ppr_vec", 32'(ppr_vec), 5);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R10 serv word1", rd_serv, 32'h0);

    // R9 ack takes 40 while 40 is requested again (level)
    step(1, 8'd40, 1, 1, 0, 1, 1);
    chk("R9 ack_vec", 32'(ack_vec), 40);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R9 pend word1", rd_pend, 32'h0);
    chk("R9 trig word1", rd_trig, 32'h0000_0102);

    // R7 retire in order, then on empty
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R7 ppr after first", 32'(ppr_vec), 40);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R7 idle", 32'(ppr_idle), 1);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R7 empty eoi", 32'(ppr_idle), 1);

    // R6 disabled acknowledge leaves 70 pending
    step(0, 0, 0, 1, 0, 0, 2);
    chk("R6 none", 32'(ack_none), 1);
    step(0, 0, 0, 0, 0, 1, 2);
    chk("R6 pend kept", rd_pend, 32'h0000_0040);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] v;
      v = ($urandom % 4 == 0) ? 8'($urandom) : 8'(($urandom % 12) * 7);
      step(($urandom % 2) == 0, v, $urandom % 2,
           ($urandom % 10) < 3, ($urandom % 4) == 0,
           ($urandom % 10) != 0, 3'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule